// File: doc/BRIEF.md
# Reference Clock Loss Monitor with Failover

This block supervises an external reference clock of about 1 MHz (50% duty cycle) by sampling it with a free-running backup oscillator clock. The reference is brought into the backup domain through a synchronizer, and its rising edges are detected there. If no rising edge arrives within a programmable silence window, the block raises a loss-of-clock flag and moves the PLL reference select to the backup source at once, with no software involvement.

Coming back to the external reference is never automatic. Software writes a self-clearing switch request bit. The request is taken only on a 0-to-1 transition of that bit, and only while the block is on the backup source with loss of clock present. A request stays pending while the reference is still absent. It completes as soon as edges are seen again. After the switch, the PLL is modelled by a lock-delay counter. Loss of clock stays reported until that delay has elapsed.

A small register port with read and write strobes, an address and data gives access to one control/status word. The current selection and the loss flag are also driven on dedicated outputs.

Top module: `clkmon_top`

## Requirements
- R1: After reset, lossOfClock is 1, refSel is 0 (backup) and the switch request bit reads 0.
- R2: When no rising edge of extRef is seen for WINDOW_US*TICKS_PER_US backup cycles, lossOfClock becomes 1 within 5 further cycles. Edges spaced closer than the window never raise it.
- R3: Loss of the reference drops refSel to 0 in the same cycle that lossOfClock is set, without any register access.
- R4: While on the backup source, refSel stays 0 with the reference present until a switch request is made.
- R5: The switch request is bit 4 of the word at address 0. Writing 1 there while it reads 0, with the block on backup, makes it pending (reads 1). It clears itself when refSel moves to 1. Writing 0 to it does nothing.
- R6: A request made while the reference is absent is held pending with refSel at 0. The switch completes once edges return.
- R7: A request written while refSel is 1 (locking or locked) has no effect, and the bit reads 0 on the next read.
- R8: After the switch, lossOfClock stays 1 and the locked bit stays 0 for LOCK_US*TICKS_PER_US cycles. Then lossOfClock becomes 0 and locked becomes 1.
- R9: Loss of the reference during the lock delay returns refSel to 0, with lossOfClock kept at 1.
- R10: The status word at address 0 has the following bits: bit0 loss of clock, bit1 external selected, bit2 locked, bit3 reference present, bit4 switch request; all other bits are 0. rdData updates in the cycle after rdEn. Other addresses read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Backup oscillator clock |
| rstN | input | 1 | Active-low reset |
| extRef | input | 1 | External reference clock, asynchronous |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data, registered |
| refSel | output | 1 | PLL reference select, 1 = external |
| lossOfClock | output | 1 | Loss-of-clock flag |

## Verification
The hardest state to reach is an abort during the lock delay: the reference has to vanish after a switch request has completed but before the lock counter expires. The bench reaches it with a directed sequence. It restarts the reference, issues a request, and stops the reference generator about twenty cycles into the lock delay. The pending-while-absent case is reached in a similar way, by writing the request before restarting the reference. Random phases mix reference start/stop, varying periods and stray writes, and the bench tracks the expected mode in a model.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;
  typedef enum logic [1:0] {
    MODE_BACKUP   = 2'd0,
    MODE_LOCKING  = 2'd1,
    MODE_EXTERNAL = 2'd2
  } refMode_t;

  // control -> datapath
  typedef struct packed {
    logic runLock;
  } dpStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic refAlive;
    logic lockDone;
  } dpFlags_t;

  localparam int STAT_LOSS    = 0;
  localparam int STAT_SEL     = 1;
  localparam int STAT_LOCKED  = 2;
  localparam int STAT_PRESENT = 3;
  localparam int STAT_REQ     = 4;
endpackage

// File: rtl/clkmon_datapath.sv
module clkmon_datapath
  import clkmon_pkg::*;
#(
  parameter int WINDOW_CYCLES = 400,
  parameter int LOCK_CYCLES   = 2500,
  parameter int SYNC_STAGES   = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      extRef,
  input  dpStrobe_t strobe,
  output dpFlags_t  flags
);
  localparam int SIL_W  = $clog2(WINDOW_CYCLES + 1);
  localparam int LOCK_W = $clog2(LOCK_CYCLES + 1);
  localparam logic [SIL_W-1:0]  SIL_MAX  = SIL_W'(WINDOW_CYCLES);
  localparam logic [LOCK_W-1:0] LOCK_END = LOCK_W'(LOCK_CYCLES - 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic                   riseSeen;
  logic [SIL_W-1:0]       silentCnt;
  logic [LOCK_W-1:0]      lockCnt;

  // synchronizer chain, stage count chosen by parameter
  generate
    if (SYNC_STAGES == 1) begin : gSyncOne
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '0;
        else       syncQ <= extRef;
    end else begin : gSyncChain
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], extRef};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= syncQ[SYNC_STAGES-1];

  assign riseSeen = syncQ[SYNC_STAGES-1] & ~prevQ;

  // cycles since last rising edge, saturating at the window length
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  silentCnt <= SIL_MAX;
    else if (riseSeen)          silentCnt <= '0;
    else if (silentCnt != SIL_MAX) silentCnt <= silentCnt + 1'b1;
  end

  // PLL lock model
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               lockCnt <= '0;
    else if (strobe.runLock) lockCnt <= (lockCnt == LOCK_END) ? lockCnt : lockCnt + 1'b1;
    else                     lockCnt <= '0;
  end

  assign flags.refAlive = (silentCnt != SIL_MAX);
  assign flags.lockDone = strobe.runLock && (lockCnt == LOCK_END);
endmodule

// File: rtl/clkmon_ctrl.sv
module clkmon_ctrl
  import clkmon_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  dpFlags_t          flags,
  output dpStrobe_t         strobe,
  output logic [DATA_W-1:0] rdData,
  output logic              refSel,
  output logic              lossOfClock,
  output logic              switchReq
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;

  refMode_t          mode;
  logic              lossQ;
  logic              pendQ;
  logic              reqRise;
  logic [DATA_W-1:0] statusWord;
  logic              unusedWrBits;

  assign unusedWrBits = ^wrData;

  // 0 -> 1 transition of the request bit as seen by software
  assign reqRise = wrEn && (addr == CTRL_ADDR) && wrData[STAT_REQ] && !pendQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode  <= MODE_BACKUP;
      lossQ <= 1'b1;
      pendQ <= 1'b0;
    end else begin
      case (mode)
        MODE_BACKUP: begin
          if (!flags.refAlive) lossQ <= 1'b1;
          if (pendQ && flags.refAlive) begin
            mode  <= MODE_LOCKING;
            pendQ <= 1'b0;
          end else if (reqRise) begin
            pendQ <= 1'b1;
          end
        end
        MODE_LOCKING: begin
          if (!flags.refAlive) begin
            mode  <= MODE_BACKUP;
            lossQ <= 1'b1;
          end else if (flags.lockDone) begin
            mode  <= MODE_EXTERNAL;
            lossQ <= 1'b0;
          end
        end
        MODE_EXTERNAL: begin
          if (!flags.refAlive) begin
            mode  <= MODE_BACKUP;
            lossQ <= 1'b1;
          end
        end
        default: begin
          mode  <= MODE_BACKUP;
          lossQ <= 1'b1;
          pendQ <= 1'b0;
        end
      endcase
    end
  end

  assign strobe.runLock = (mode == MODE_LOCKING);
  assign refSel         = (mode != MODE_BACKUP);
  assign lossOfClock    = lossQ;
  assign switchReq      = pendQ;

  always_comb begin
    statusWord               = '0;
    statusWord[STAT_LOSS]    = lossQ;
    statusWord[STAT_SEL]     = refSel;
    statusWord[STAT_LOCKED]  = (mode == MODE_EXTERNAL);
    statusWord[STAT_PRESENT] = flags.refAlive;
    statusWord[STAT_REQ]     = pendQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= (addr == CTRL_ADDR) ? statusWord : '0;
  end
endmodule

// File: rtl/clkmon_top.sv
module clkmon_top
  import clkmon_pkg::*;
#(
  parameter int TICKS_PER_US = 100,
  parameter int WINDOW_US    = 4,
  parameter int LOCK_US      = 25,
  parameter int SYNC_STAGES  = 2,
  parameter int ADDR_W       = 4,
  parameter int DATA_W       = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extRef,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              refSel,
  output logic              lossOfClock
);
  localparam int WINDOW_CYCLES = WINDOW_US * TICKS_PER_US;
  localparam int LOCK_CYCLES   = LOCK_US * TICKS_PER_US;

  dpStrobe_t strobe;
  dpFlags_t  flags;
  logic      switchReq;

  clkmon_datapath #(
    .WINDOW_CYCLES(WINDOW_CYCLES),
    .LOCK_CYCLES  (LOCK_CYCLES),
    .SYNC_STAGES  (SYNC_STAGES)
  ) uDp (
    .clk   (clk),
    .rstN  (rstN),
    .extRef(extRef),
    .strobe(strobe),
    .flags (flags)
  );

  clkmon_ctrl #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .rdEn       (rdEn),
    .addr       (addr),
    .wrData     (wrData),
    .flags      (flags),
    .strobe     (strobe),
    .rdData     (rdData),
    .refSel     (refSel),
    .lossOfClock(lossOfClock),
    .switchReq  (switchReq)
  );
endmodule

// File: rtl/clkmon_checker.sv
module clkmon_checker #(
  parameter int TICKS_PER_US = 100,
  parameter int LOCK_US      = 25,
  parameter int ADDR_W       = 4,
  parameter int DATA_W       = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              refSel,
  input logic              lossOfClock,
  input logic              switchReq,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdData
);
  localparam int LOCK_CYCLES = LOCK_US * TICKS_PER_US;
  localparam int CNT_W       = $clog2(LOCK_CYCLES + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] lockRun;

  // cycles spent on the external source while loss is still reported
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      lockRun <= '0;
    else if (refSel && lossOfClock) lockRun <= (lockRun == CNT_MAX) ? lockRun : lockRun + 1'b1;
    else                            lockRun <= '0;
  end

  assert_failover_flags_loss_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(refSel) |-> lossOfClock);

  assert_return_needs_request_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(refSel) |-> $past(switchReq));

  assert_request_only_on_backup_R5: assert property (@(posedge clk) disable iff (!rstN)
    switchReq |-> !refSel);

  assert_loss_clears_on_external_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lossOfClock) |-> refSel);

  assert_lock_delay_length_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lossOfClock) |-> (lockRun == CNT_W'(LOCK_CYCLES)));

  assert_other_addr_reads_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    $past(rdEn && (addr != '0)) |-> (rdData == '0));
endmodule

bind clkmon_top clkmon_checker #(
  .TICKS_PER_US(TICKS_PER_US),
  .LOCK_US     (LOCK_US),
  .ADDR_W      (ADDR_W),
  .DATA_W      (DATA_W)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .refSel     (refSel),
  .lossOfClock(lossOfClock),
  .switchReq  (switchReq),
  .rdEn       (rdEn),
  .addr       (addr),
  .rdData     (rdData)
);

// File: tb/sim_clkmon_top.sv
`timescale 1ns/1ps
module sim_clkmon_top;
  localparam int TICKS  = 4;
  localparam int WIN_US = 4;
  localparam int LCK_US = 25;
  localparam int WINDOW = TICKS * WIN_US;
  localparam int LOCK   = TICKS * LCK_US;
  localparam int SETTLE = WINDOW + LOCK + 30;
  localparam int AW = 4;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          extRef = 1'b0;
  logic          wrEn = 1'b0;
  logic          rdEn = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic          refSel;
  logic          lossOfClock;

  int  tests = 0;
  int  fails = 0;
  bit  done  = 0;
  bit  refOn = 0;
  int  halfNs = 16;

  // bench model
  bit  mExt = 0;
  bit  mPend = 0;

  always #2.5 clk = ~clk;

  clkmon_top #(
    .TICKS_PER_US(TICKS), .WINDOW_US(WIN_US), .LOCK_US(LCK_US),
    .ADDR_W(AW), .DATA_W(DW)
  ) u0 (
    .clk(clk), .rstN(rstN), .extRef(extRef), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .refSel(refSel),
    .lossOfClock(lossOfClock)
  );

  // asynchronous reference generator
  always begin
    if (refOn) begin
      extRef = ~extRef;
      #(halfNs);
    end else begin
      extRef = 1'b0;
      #1;
    end
  end

  function automatic logic [DW-1:0] expStatus(bit ext, bit present, bit pend);
    logic [DW-1:0] s;
    s = '0;
    s[0] = !ext;
    s[1] = ext;
    s[2] = ext;
    s[3] = present;
    s[4] = pend;
    return s;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic regWrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; addr = '0; wrData = '0;
  endtask

  task automatic regRead(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0; addr = '0;
    d = rdData;
  endtask

  task automatic startRef(input int halfCyc);
    halfNs = halfCyc * 5 + 1;
    refOn  = 1;
  endtask

  // half period between 2 and 4 backup cycles keeps the period well inside the window
  function automatic int randHalf();
    return 2 + int'($urandom % 3);
  endfunction

  initial begin
    logic [DW-1:0] rd;
    void'($urandom(32'h5eed_c10c));
    waitCyc(5);
    rstN = 1'b1;
    waitCyc(2);

    // R1 reset state
    chk("R1 lossOfClock", 32'(lossOfClock), 32'd1);
    chk("R1 refSel", 32'(refSel), 32'd0);
    regRead(0, rd);
    chk("R1 status", 32'(rd), 32'h01);
    // R10 other address reads zero
    regRead(2, rd);
    chk("R10 other addr read", 32'(rd), 32'h0);

    // R5 writing 0 to the request bit does nothing
    regWrite(0, 16'hFFEF);
    regRead(0, rd);
    chk("R5 zero write", 32'(rd), 32'h01);

    // R6 request while reference absent is held
    regWrite(0, 16'h0010);
    waitCyc(40);
    regRead(0, rd);
    chk("R6 pending held", 32'(rd), 32'h11);
    chk("R6 refSel backup", 32'(refSel), 32'd0);

    // reference returns: pending request completes, lock delay starts
    startRef(3);
    waitCyc(30);
    regRead(0, rd);
    chk("R8 locking status", 32'(rd), 32'h0B);
    chk("R5 request self-cleared", 32'(rd[4]), 32'd0);

    // R7 request during locking has no effect
    regWrite(0, 16'h0010);
    regRead(0, rd);
    chk("R7 request while locking", 32'(rd), 32'h0B);

    waitCyc(LOCK);
    regRead(0, rd);
    chk("R8 locked status", 32'(rd), 32'h0E);
    chk("R8 loss cleared", 32'(lossOfClock), 32'd0);
    chk("R2 no loss with edges", 32'(lossOfClock), 32'd0);

    // R7 request with no loss clears immediately
    regWrite(0, 16'h0010);
    regRead(0, rd);
    chk("R7 request on external", 32'(rd), 32'h0E);

    // R2/R3 reference stops
    refOn = 0;
    waitCyc(WINDOW + 8);
    chk("R2 loss detected", 32'(lossOfClock), 32'd1);
    chk("R3 failover", 32'(refSel), 32'd0);
    regRead(0, rd);
    chk("R3 status after failover", 32'(rd), 32'h01);

    // R4 no automatic return
    startRef(2);
    waitCyc(200);
    chk("R4 stays on backup", 32'(refSel), 32'd0);
    regRead(0, rd);
    chk("R4 status", 32'(rd), 32'h09);

    // R9 loss during the lock delay
    regWrite(0, 16'h0010);
    waitCyc(20);
    chk("R9 locking entered", 32'(refSel), 32'd1);
    refOn = 0;
    waitCyc(WINDOW + 8);
    chk("R9 back to backup", 32'(refSel), 32'd0);
    chk("R9 loss kept", 32'(lossOfClock), 32'd1);
    regRead(0, rd);
    chk("R9 status", 32'(rd), 32'h01);

    // R10 write to another address is ignored
    regWrite(3, 16'hFFFF);
    regRead(0, rd);
    chk("R10 stray write ignored", 32'(rd), 32'h01);

    // random phase
    mExt = 0; mPend = 0;
    for (int it = 0; it < 40; it++) begin
      int act;
      act = int'($urandom % 4);
      case (act)
        0: begin
          refOn = 0;
          mExt  = 0;
        end
        1: begin
          startRef(randHalf());
          if (mPend) begin mExt = 1; mPend = 0; end
        end
        2: begin
          regWrite(0, 16'($urandom) | 16'h0010);
          if (!mExt && !mPend) begin
            mPend = 1;
            if (refOn) begin mExt = 1; mPend = 0; end
          end
        end
        default: begin
          regWrite(AW'(1 + ($urandom % 15)), 16'($urandom));
        end
      endcase
      waitCyc(SETTLE);
      regRead(0, rd);
      chk("R10 random status", 32'(rd), 32'(expStatus(mExt, refOn, mPend)));
      chk("R3 random refSel", 32'(refSel), 32'(mExt));
      chk("R2 random loss", 32'(lossOfClock), 32'(!mExt));
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule